// File: doc/BRIEF.md
# Message Interrupt Capture Queue

This block takes in message-signalled interrupt writes arriving as a valid/address/data strobe. When capture is enabled and the 64-bit write address falls inside a programmed window, the 32-bit payload and the full 64-bit address are stored together as one entry in a small queue. The queue is read through a plain 32-bit register port.

A level interrupt tells the host that a message is waiting. Software reads three registers for the oldest entry: the payload word, the low address word and the high address word. The entry leaves the queue only once all three have been read, so the pending flag and the interrupt drop only after the last of the three reads.

In normal use, software sets the window to 4096 bytes. Vector n writes payload n to window base plus 4·n.

Top module: `msi_capture_unit`

## Requirements
- R1: Registers at byte offsets 0x04 (window base bits 31:0), 0x08 (window base bits 63:32) and 0x0C (window size in bytes, 32 bits) read back the value last written. The enable register at 0x14 reads back bit 0 of the value last written, with bits 31:1 reading zero.
- R2: A strobe with msg_valid=1 is stored when all three of these hold: enable bit 0 is 1, the address is at least the base, and the address is below base+size. Status bit 0 (offset 0x18) then reads 1.
- R3: A strobe whose address is below the base, or at or above base+size, is not stored.
- R4: A strobe arriving while enable bit 0 is 0 is not stored, even if its address is inside the window.
- R5: Entries leave the queue in arrival order. Offset 0x20 returns the payload, 0x24 returns address bits 31:0 and 0x28 returns address bits 63:32 of the oldest entry.
- R6: The oldest entry is removed only after each of 0x20, 0x24 and 0x28 has been read at least once, in any order. Status bit 0 keeps reading 1 until then if that was the only entry.
- R7: The queue holds 16 entries. A strobe that would be stored while 16 entries are held is dropped and sets the sticky status bit 1. Writing a value with bit 1 set to offset 0x18 clears bit 1.
- R8: irq_o equals status bit 0 in every cycle.
- R9: Reading 0x20, 0x24 or 0x28 while the queue is empty returns zero and removes nothing.
- R10: reg_rdata carries the read value in the cycle after reg_rd_en is sampled and is zero otherwise. Unmapped offsets read zero.
- R11: After reset, all registers read zero, the queue is empty and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the read strobe |
| msg_valid | input | 1 | Inbound message write strobe |
| msg_addr | input | 64 | Inbound message write address |
| msg_data | input | 32 | Inbound message payload |
| irq_o | output | 1 | Message pending interrupt |

## Verification
Strobes are sent at the first and last word of the window, one byte below it, at base+size, and while capture is disabled. These cases separate an inclusive bound from an exclusive one and show whether enable gates the capture. The three registers of an entry are read in several orders, with the pending flag checked between reads, to show that removal waits for the third read and does not follow one fixed register. Filling past sixteen entries and then draining shows the drop-on-full behaviour and the sticky flag, and a later entry that should be absent would reveal an off-by-one depth.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int REG_AW = 8;
  localparam int DW     = 32;
  localparam int AW     = 64;

  localparam logic [REG_AW-1:0] OFS_BASE_LO = 8'h04;
  localparam logic [REG_AW-1:0] OFS_BASE_HI = 8'h08;
  localparam logic [REG_AW-1:0] OFS_SIZE    = 8'h0C;
  localparam logic [REG_AW-1:0] OFS_ENABLE  = 8'h14;
  localparam logic [REG_AW-1:0] OFS_STATUS  = 8'h18;
  localparam logic [REG_AW-1:0] OFS_DATA    = 8'h20;
  localparam logic [REG_AW-1:0] OFS_ADR_LO  = 8'h24;
  localparam logic [REG_AW-1:0] OFS_ADR_HI  = 8'h28;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } msg_entry_t;

  localparam int ENTRY_W = AW + DW;
endpackage

// File: rtl/msi_cap_window.sv
module msi_cap_window #(
  parameter int AW = 64,
  parameter int SW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i,
  input  logic [SW-1:0] size_i,
  output logic          hit_o
);
  logic [AW-1:0] offset;
  logic          above;

  always_comb begin
    above  = (addr_i >= base_i);
    offset = addr_i - base_i;
    hit_o  = above && (offset < {{(AW-SW){1'b0}}, size_i});
  end
endmodule

// File: rtl/msi_cap_fifo.sv
module msi_cap_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 96
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
  localparam logic [PW-1:0] PTR_MAX = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, wr_ptr_nxt, rd_ptr, rd_ptr_nxt;
  logic [CW-1:0]    cnt, cnt_nxt;
  logic             do_push, do_pop;

  always_comb begin
    do_push    = push_i && (cnt != CNT_MAX);
    do_pop     = pop_i && (cnt != '0);
    wr_ptr_nxt = wr_ptr;
    rd_ptr_nxt = rd_ptr;
    cnt_nxt    = cnt;
    if (do_push) wr_ptr_nxt = (wr_ptr == PTR_MAX) ? '0 : wr_ptr + 1'b1;
    if (do_pop)  rd_ptr_nxt = (rd_ptr == PTR_MAX) ? '0 : rd_ptr + 1'b1;
    if (do_push && !do_pop) cnt_nxt = cnt + 1'b1;
    else if (do_pop && !do_push) cnt_nxt = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      cnt    <= cnt_nxt;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && (wr_ptr == PW'(g))) mem[g] <= wdata_i;
    end
  end

  assign head_o  = mem[rd_ptr];
  assign full_o  = (cnt == CNT_MAX);
  assign empty_o = (cnt == '0);

  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !pop_i) |=> full_o);
  a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i) |=> $stable(cnt));
endmodule

// File: rtl/msi_cap_pop_track.sv
module msi_cap_pop_track (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_data_i,
  input  logic rd_lo_i,
  input  logic rd_hi_i,
  input  logic nonempty_i,
  output logic pop_o
);
  logic [2:0] seen, seen_nxt, merged;

  always_comb begin
    merged   = seen | {rd_hi_i, rd_lo_i, rd_data_i};
    pop_o    = 1'b0;
    seen_nxt = seen;
    if (nonempty_i) begin
      if (merged == 3'b111) begin
        pop_o    = 1'b1;
        seen_nxt = 3'b000;
      end else begin
        seen_nxt = merged;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 3'b000;
    else        seen <= seen_nxt;
  end

  a_r6_pop_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    pop_o |-> nonempty_i);
  a_r6_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    pop_o |=> (seen == 3'b000));
endmodule

// File: rtl/msi_capture_unit.sv
module msi_capture_unit
  import msi_cap_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              msg_valid,
  input  logic [AW-1:0]     msg_addr,
  input  logic [DW-1:0]     msg_data,
  output logic              irq_o
);
  logic [AW-1:0] base_q;
  logic [DW-1:0] size_q;
  logic          en_q, ovf_q, ovf_nxt;
  logic [DW-1:0] rdata_q, rdata_nxt;
  logic          hit, accept, push, pop, full, empty;
  msg_entry_t    new_ent, head_ent, head_vis;
  logic          rd_data, rd_lo, rd_hi;

  msi_cap_window #(.AW(AW), .SW(DW)) u_window (
    .addr_i(msg_addr), .base_i(base_q), .size_i(size_q), .hit_o(hit)
  );

  always_comb begin
    accept       = msg_valid && en_q && hit;
    push         = accept && !full;
    new_ent.addr = msg_addr;
    new_ent.data = msg_data;
  end

  msi_cap_fifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(push), .wdata_i(new_ent),
    .pop_i(pop), .head_o(head_ent), .full_o(full), .empty_o(empty)
  );

  always_comb begin
    rd_data = reg_rd_en && (reg_addr == OFS_DATA);
    rd_lo   = reg_rd_en && (reg_addr == OFS_ADR_LO);
    rd_hi   = reg_rd_en && (reg_addr == OFS_ADR_HI);
  end

  msi_cap_pop_track u_pop (
    .clk(clk), .rst_n(rst_n), .rd_data_i(rd_data), .rd_lo_i(rd_lo),
    .rd_hi_i(rd_hi), .nonempty_i(!empty), .pop_o(pop)
  );

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
      en_q   <= 1'b0;
    end else if (reg_wr_en) begin
      if (reg_addr == OFS_BASE_LO) base_q[31:0]  <= reg_wdata;
      if (reg_addr == OFS_BASE_HI) base_q[63:32] <= reg_wdata;
      if (reg_addr == OFS_SIZE)    size_q        <= reg_wdata;
      if (reg_addr == OFS_ENABLE)  en_q          <= reg_wdata[0];
    end
  end

  // sticky overflow: a new drop wins over a same-cycle clear
  always_comb begin
    ovf_nxt = ovf_q;
    if (reg_wr_en && (reg_addr == OFS_STATUS) && reg_wdata[1]) ovf_nxt = 1'b0;
    if (accept && full) ovf_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_nxt;
  end

  always_comb begin
    head_vis  = empty ? '0 : head_ent;
    rdata_nxt = '0;
    if (reg_rd_en) begin
      unique case (reg_addr)
        OFS_BASE_LO: rdata_nxt = base_q[31:0];
        OFS_BASE_HI: rdata_nxt = base_q[63:32];
        OFS_SIZE:    rdata_nxt = size_q;
        OFS_ENABLE:  rdata_nxt = {31'b0, en_q};
        OFS_STATUS:  rdata_nxt = {30'b0, ovf_q, !empty};
        OFS_DATA:    rdata_nxt = head_vis.data;
        OFS_ADR_LO:  rdata_nxt = head_vis.addr[31:0];
        OFS_ADR_HI:  rdata_nxt = head_vis.addr[63:32];
        default:     rdata_nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_nxt;
  end

  assign reg_rdata = rdata_q;
  assign irq_o     = !empty;

  a_r2_capture_pending: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> irq_o);
  a_r4_disabled_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && empty) |=> empty);
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !reg_wr_en) |=> ovf_q);
  a_r9_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_data || rd_lo || rd_hi) && empty) |=> (reg_rdata == '0));
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> (reg_rdata == '0));
endmodule

// File: tb/msi_capture_unit_tb.sv
module msi_capture_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        reg_wr_en, reg_rd_en;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        msg_valid;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;
  logic        irq_o;

  msi_capture_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
    .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // behavioural model
  logic [95:0] mq[$];
  logic [63:0] m_base;
  logic [31:0] m_size;
  bit          m_en, m_ovf;
  bit [2:0]    m_seen;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // R8: interrupt compared against the model on every clock
  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    if (rst_n && !done) check("R8", {31'b0, irq_o}, {31'b0, mq.size() != 0});
  end

  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [95:0] h;
    h = (mq.size() != 0) ? mq[0] : '0;
    case (a)
      8'h04: return m_base[31:0];
      8'h08: return m_base[63:32];
      8'h0C: return m_size;
      8'h14: return {31'b0, m_en};
      8'h18: return {30'b0, m_ovf, mq.size() != 0};
      8'h20: return h[31:0];
      8'h24: return h[63:32];
      8'h28: return h[95:64];
      default: return 32'h0;
    endcase
  endfunction

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    case (a)
      8'h04: m_base[31:0]  = d;
      8'h08: m_base[63:32] = d;
      8'h0C: m_size        = d;
      8'h14: m_en          = d[0];
      8'h18: if (d[1]) m_ovf = 0;
      default: ;
    endcase
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, input string req);
    logic [31:0] exp;
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    exp = model_read(a);
    if (mq.size() != 0 && (a == 8'h20 || a == 8'h24 || a == 8'h28)) begin
      m_seen |= (a == 8'h20) ? 3'b001 : (a == 8'h24) ? 3'b010 : 3'b100;
      if (m_seen == 3'b111) begin
        void'(mq.pop_front());
        m_seen = 0;
      end
    end
    @(negedge clk);
    reg_rd_en = 1'b0;
    check(req, reg_rdata, exp);
  endtask

  task automatic send(input logic [63:0] a, input logic [31:0] d);
    logic [64:0] lim;
    @(negedge clk);
    msg_valid = 1'b1; msg_addr = a; msg_data = d;
    lim = {1'b0, m_base} + {33'b0, m_size};
    if (m_en && a >= m_base && {1'b0, a} < lim) begin
      if (mq.size() < 16) mq.push_back({a, d});
      else m_ovf = 1;
    end
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic drain_one(input string req);
    reg_read(8'h20, req);
    reg_read(8'h24, req);
    reg_read(8'h28, req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] b;
    rst_n = 0; reg_wr_en = 0; reg_rd_en = 0; reg_addr = 0; reg_wdata = 0;
    msg_valid = 0; msg_addr = 0; msg_data = 0;
    m_base = 0; m_size = 0; m_en = 0; m_ovf = 0; m_seen = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11 reset state
    check("R11", {31'b0, irq_o}, 32'h0);
    reg_read(8'h18, "R11");
    reg_read(8'h04, "R11");
    reg_read(8'h14, "R11");
    reg_read(8'h20, "R11");

    // R1 programming
    b = 64'h0000_0001_F000_0000;
    reg_write(8'h04, b[31:0]);
    reg_write(8'h08, b[63:32]);
    reg_write(8'h0C, 32'd4096);
    reg_write(8'h14, 32'hFFFF_FFFF);
    reg_read(8'h04, "R1"); reg_read(8'h08, "R1");
    reg_read(8'h0C, "R1"); reg_read(8'h14, "R1");
    reg_read(8'h3C, "R10");

    // R2 capture of vector 3
    send(b + 64'd12, 32'd3);
    reg_read(8'h18, "R2");
    // R3 outside the window, R4 disabled
    send(b - 64'd1, 32'hAA);
    send(b + 64'd4096, 32'hBB);
    reg_write(8'h14, 32'h0);
    send(b + 64'd4, 32'hCC);
    reg_write(8'h14, 32'h1);
    // R6 status held until third read
    reg_read(8'h20, "R5");
    reg_read(8'h18, "R6");
    reg_read(8'h24, "R5");
    reg_read(8'h18, "R6");
    reg_read(8'h28, "R5");
    reg_read(8'h18, "R3 R4 R6");
    // R9 empty reads
    reg_read(8'h20, "R9"); reg_read(8'h28, "R9"); reg_read(8'h18, "R9");

    // R5 ordering with varied read orders, boundary addresses
    send(b, 32'd0);
    send(b + 64'd4092, 32'd15);
    send(b + 64'd28, 32'd7);
    reg_read(8'h28, "R6"); reg_read(8'h20, "R6"); reg_read(8'h28, "R6");
    reg_read(8'h24, "R6");
    reg_read(8'h24, "R5"); reg_read(8'h24, "R6"); reg_read(8'h28, "R5");
    reg_read(8'h20, "R5");
    drain_one("R5");
    reg_read(8'h18, "R5");

    // R7 overflow
    for (int i = 0; i < 17; i++) send(b + 64'(4 * (i % 16)), 32'(i));
    reg_read(8'h18, "R7");
    for (int i = 0; i < 16; i++) drain_one("R7");
    reg_read(8'h18, "R7");
    reg_read(8'h20, "R7");
    reg_write(8'h18, 32'h2);
    reg_read(8'h18, "R7");

    repeat (2) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule